// File: doc/BRIEF.md
# Serial Path Overhead Insertion Port

This block lets logic outside the chip supply path overhead bytes for an STS-1 synchronous payload envelope one bit at a time. It divides the system clock down to a port clock and drives two indicators with it. One is a per-byte ready pulse. The other is a frame marker for the first overhead byte of each envelope. It then collects eight serial bits together with an insert-request bit for every overhead byte. Each byte is reported with its position in the overhead column and a flag. The flag says whether the external byte should replace the internally generated one, or whether the transfer was only partly requested and has to be dropped.

The payload timing logic asks for each overhead byte with a single-cycle trigger, and marks the trigger of the first byte of an envelope with a start-of-frame strobe. One port timing engine is shared by a parameterised number of identical data lanes, three by default. Each lane has its own serial data and insert-request inputs and its own result. The port clock's falling edge is modelled as a sample enable at the middle of each port-clock period, so the whole block runs on the system clock.

Top module: `poh_serial_ins`

## Requirements
- R1: The port clock has a period of DIV system clocks (default 8) and stays high for DIV/2 cycles and low for DIV/2 cycles.
- R2: After reset the port clock, both indicators, the result strobe and all flags are low. Triggers are ignored until one arrives together with the start-of-frame strobe.
- R3: After an accepted trigger, the ready indicator rises with the next port-clock rising edge and stays high for exactly one port-clock period. It is low at all other times.
- R4: For a byte accepted with the start-of-frame strobe, the frame indicator rises together with the ready indicator and stays high for exactly eight port-clock periods. For all other bytes it stays low.
- R5: A lane samples its serial bit and its insert request at the falling edge (DIV/2 system clocks after the rise) of each of the eight port-clock periods that follow the ready period. The first bit sampled is the most significant bit of the byte.
- R6: When a lane's insert request is sampled high on all eight bits, its override flag is 1, its error flag is 0 and its byte output carries the assembled byte.
- R7: When a lane's insert request is sampled low on all eight bits, its override and error flags are 0 and its byte output is 0.
- R8: When a lane's insert request is high on some bits but not all, its error flag is 1, its override flag is 0 and its byte output is 0.
- R9: The byte index is 0 for a byte accepted with start-of-frame and rises by one per accepted trigger otherwise, wrapping from 8 to 0. The order is J1=0, B3=1, C2=2, G1=3, F2=4, H4=5, Z3=6, Z4=7, Z5=8. Each result carries the index of its own byte.
- R10: The result strobe is high for exactly one system cycle, starting right after the eighth sample edge. Byte and flag outputs are 0 whenever the strobe is low.
- R11: A trigger that arrives while a byte is being announced or transferred is ignored, with or without start-of-frame, except on the final sample edge.
- R12: A trigger that coincides with the final sample edge of the current byte is accepted. The finishing byte is still reported with its own index.
- R13: Lanes are independent: each lane's result depends only on its own serial data and insert-request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_tick_i | input | 1 | Single-cycle request for the next overhead byte |
| sof_i | input | 1 | Marks byte_tick_i as the first byte of an envelope |
| ser_data_i | input | NCH | Serial overhead data, one bit per lane |
| ins_req_i | input | NCH | Insert request, one bit per lane |
| pclk_o | output | 1 | Divided port clock |
| frame_o | output | 1 | Envelope frame indicator |
| rdy_o | output | 1 | Byte-ready indicator |
| byte_o | output | NCH*BW | Assembled bytes, lane 0 in the low bits |
| idx_o | output | 4 | Overhead byte index of the reported byte |
| valid_o | output | 1 | Result strobe |
| ovr_o | output | NCH | Per-lane override flag |
| err_o | output | NCH | Per-lane partial-request error flag |

## Verification
Two things can happen on the same edge: the final sample of one byte, and the acceptance of the trigger for the next. At that edge the design reports the finished result and starts a new announce sequence. The bench provokes this by counting half a port-clock period from the rise of the eighth bit period and placing a trigger exactly on that sample edge. It then checks two things: the finishing byte still carries its own index and data, and the new byte is announced on the very next port-clock rise with the incremented index. Random plans mix full, absent and partial insert requests per lane, and add ignored triggers in the middle of a transfer.

// File: rtl/poh_ins_pkg.sv
package poh_ins_pkg;

  // overhead bytes per envelope column
  localparam int POH_BYTES = 9;
  localparam int IDX_W     = $clog2(POH_BYTES);

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARM   = 2'd1,
    SEQ_ANN   = 2'd2,
    SEQ_SHIFT = 2'd3
  } seq_state_t;

endpackage

// File: rtl/poh_pclk_gen.sv
module poh_pclk_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic pclk_o,
  output logic rise_tick,
  output logic samp_tick
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  // rise_tick: edge at which the port clock goes high
  // samp_tick: edge at which it goes low (the sampling edge)
  assign rise_tick = (cnt == CNT_LAST);
  assign samp_tick = (cnt == CNT_MID);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      pclk_o <= 1'b0;
    end else begin
      cnt <= rise_tick ? '0 : cnt + 1'b1;
      if (rise_tick)
        pclk_o <= 1'b1;
      else if (samp_tick)
        pclk_o <= 1'b0;
    end
  end

endmodule

// File: rtl/poh_byte_seq.sv
module poh_byte_seq
  import poh_ins_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_tick,
  input  logic             samp_tick,
  input  logic             byte_tick_i,
  input  logic             sof_i,
  output logic             rdy_o,
  output logic             frame_o,
  output logic             samp_en,
  output logic             first_bit,
  output logic             last_bit,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int BCW = $clog2(BW);
  localparam logic [BCW-1:0]   BIT_LAST = BCW'(BW - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(POH_BYTES - 1);

  seq_state_t       st;
  logic             synced;
  logic             j1;
  logic [IDX_W-1:0] idx;
  logic [BCW-1:0]   bitc;
  logic             accept;

  assign samp_en   = (st == SEQ_SHIFT) && samp_tick;
  assign first_bit = samp_en && (bitc == '0);
  assign last_bit  = samp_en && (bitc == BIT_LAST);

  // a new byte may start from idle or on the final sample edge
  assign accept = byte_tick_i && (sof_i || synced) &&
                  ((st == SEQ_IDLE) || last_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_IDLE;
      synced  <= 1'b0;
      j1      <= 1'b0;
      idx     <= '0;
      bitc    <= '0;
      rdy_o   <= 1'b0;
      frame_o <= 1'b0;
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= last_bit;
      if (last_bit)
        idx_o <= idx;

      if (accept) begin
        synced <= 1'b1;
        j1     <= sof_i;
        if (sof_i)
          idx <= '0;
        else
          idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
        st <= SEQ_ARM;
      end else begin
        case (st)
          SEQ_ARM: begin
            if (rise_tick) begin
              st    <= SEQ_ANN;
              rdy_o <= 1'b1;
              if (j1)
                frame_o <= 1'b1;
            end
          end
          SEQ_ANN: begin
            if (rise_tick) begin
              st    <= SEQ_SHIFT;
              rdy_o <= 1'b0;
              bitc  <= '0;
            end
          end
          SEQ_SHIFT: begin
            // frame marker ends as the last bit period begins
            if (rise_tick && (bitc == BIT_LAST))
              frame_o <= 1'b0;
            if (samp_en) begin
              if (bitc == BIT_LAST)
                st <= SEQ_IDLE;
              else
                bitc <= bitc + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/poh_lane.sv
module poh_lane #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_en,
  input  logic          first_bit,
  input  logic          last_bit,
  input  logic          ser_i,
  input  logic          ins_i,
  output logic [BW-1:0] byte_o,
  output logic          ovr_o,
  output logic          err_o
);
  logic [BW-1:0] sh;
  logic          all_q;
  logic          any_q;
  logic [BW-1:0] sh_n;
  logic          all_n;
  logic          any_n;

  always_comb begin
    if (first_bit) begin
      sh_n  = {{(BW-1){1'b0}}, ser_i};
      all_n = ins_i;
      any_n = ins_i;
    end else begin
      sh_n  = {sh[BW-2:0], ser_i};
      all_n = all_q & ins_i;
      any_n = any_q | ins_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      all_q  <= 1'b0;
      any_q  <= 1'b0;
      byte_o <= '0;
      ovr_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      byte_o <= '0;
      ovr_o  <= 1'b0;
      err_o  <= 1'b0;
      if (samp_en) begin
        sh    <= sh_n;
        all_q <= all_n;
        any_q <= any_n;
      end
      if (last_bit) begin
        ovr_o  <= all_n;
        err_o  <= any_n & ~all_n;
        byte_o <= all_n ? sh_n : '0;
      end
    end
  end

endmodule

// File: rtl/poh_serial_ins.sv
module poh_serial_ins
  import poh_ins_pkg::*;
#(
  parameter int NCH = 3,
  parameter int BW  = 8,
  parameter int DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_tick_i,
  input  logic              sof_i,
  input  logic [NCH-1:0]    ser_data_i,
  input  logic [NCH-1:0]    ins_req_i,
  output logic              pclk_o,
  output logic              frame_o,
  output logic              rdy_o,
  output logic [NCH*BW-1:0] byte_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o,
  output logic [NCH-1:0]    ovr_o,
  output logic [NCH-1:0]    err_o
);
  logic rise_tick;
  logic samp_tick;
  logic samp_en;
  logic first_bit;
  logic last_bit;

  poh_pclk_gen #(.DIV(DIV)) pclk_i (
    .clk       (clk),
    .rst       (rst),
    .pclk_o    (pclk_o),
    .rise_tick (rise_tick),
    .samp_tick (samp_tick)
  );

  poh_byte_seq #(.BW(BW)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .rise_tick   (rise_tick),
    .samp_tick   (samp_tick),
    .byte_tick_i (byte_tick_i),
    .sof_i       (sof_i),
    .rdy_o       (rdy_o),
    .frame_o     (frame_o),
    .samp_en     (samp_en),
    .first_bit   (first_bit),
    .last_bit    (last_bit),
    .valid_o     (valid_o),
    .idx_o       (idx_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    poh_lane #(.BW(BW)) lane_i (
      .clk       (clk),
      .rst       (rst),
      .samp_en   (samp_en),
      .first_bit (first_bit),
      .last_bit  (last_bit),
      .ser_i     (ser_data_i[g]),
      .ins_i     (ins_req_i[g]),
      .byte_o    (byte_o[g*BW +: BW]),
      .ovr_o     (ovr_o[g]),
      .err_o     (err_o[g])
    );
  end

endmodule

// File: rtl/poh_serial_ins_chk.sv
module poh_serial_ins_chk
  import poh_ins_pkg::*;
#(
  parameter int NCH = 3,
  parameter int BW  = 8,
  parameter int DIV = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pclk_o,
  input logic              frame_o,
  input logic              rdy_o,
  input logic [NCH*BW-1:0] byte_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic              valid_o,
  input logic [NCH-1:0]    ovr_o,
  input logic [NCH-1:0]    err_o
);
  localparam int HALF = DIV / 2;
  localparam int RW   = $clog2(DIV) + 2;

  logic          pclk_d;
  logic          seen;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_d <= 1'b0;
      seen   <= 1'b0;
      run    <= '0;
    end else if (pclk_o != pclk_d) begin
      pclk_d <= pclk_o;
      seen   <= 1'b1;
      run    <= RW'(1);
    end else if (run != '1) begin
      run <= run + 1'b1;
    end
  end

  a_r1_pclk_half: assert property (@(posedge clk) disable iff (rst)
    ((pclk_o != pclk_d) && seen) |-> (run == RW'(HALF)));

  a_r3_rdy_rise_on_pclk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_o) |-> $rose(pclk_o));

  a_r3_rdy_fall_on_pclk: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_o) |-> $rose(pclk_o));

  a_r4_frame_with_rdy: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_o) |-> $rose(rdy_o));

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    (ovr_o & err_o) == '0);

  a_r9_idx_range: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (idx_o < IDX_W'(POH_BYTES)));

  a_r10_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  a_r10_valid_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $fell(pclk_o));

  a_r10_quiet_outputs: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ((ovr_o == '0) && (err_o == '0) && (byte_o == '0)));

endmodule

bind poh_serial_ins poh_serial_ins_chk #(.NCH(NCH), .BW(BW), .DIV(DIV)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .pclk_o  (pclk_o),
  .frame_o (frame_o),
  .rdy_o   (rdy_o),
  .byte_o  (byte_o),
  .idx_o   (idx_o),
  .valid_o (valid_o),
  .ovr_o   (ovr_o),
  .err_o   (err_o)
);

// File: tb/poh_serial_ins_tb_top.sv
module poh_serial_ins_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH    = 3;
  localparam int BW     = 8;
  localparam int DIV    = 8;
  localparam int HALF   = DIV / 2;
  localparam int NBYTES = 9;
  localparam int RUN_END  = 25000;
  localparam int LOOP_END = 25300;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              byte_tick = 1'b0;
  logic              sof = 1'b0;
  logic [NCH-1:0]    ser = '0;
  logic [NCH-1:0]    ins = '0;
  logic              pclk, frame, rdy, valid;
  logic [NCH*BW-1:0] bytes;
  logic [3:0]        idx;
  logic [NCH-1:0]    ovr, err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  poh_serial_ins #(.NCH(NCH), .BW(BW), .DIV(DIV)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .byte_tick_i (byte_tick),
    .sof_i       (sof),
    .ser_data_i  (ser),
    .ins_req_i   (ins),
    .pclk_o      (pclk),
    .frame_o     (frame),
    .rdy_o       (rdy),
    .byte_o      (bytes),
    .idx_o       (idx),
    .valid_o     (valid),
    .ovr_o       (ovr),
    .err_o       (err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_ovr(input logic [BW-1:0] m);
    return (m == '1) ? 1 : 0;
  endfunction
  function automatic int exp_err(input logic [BW-1:0] m);
    return (m != '0 && m != '1) ? 1 : 0;
  endfunction
  function automatic int exp_byte(input logic [BW-1:0] m, input logic [BW-1:0] d);
    return (m == '1) ? int'(d) : 0;
  endfunction

  // bench state
  bit             pclk_d = 0;
  int             run_len = 0;
  int             pclk_changes = 0;
  int             drv_cnt = 0;
  logic [BW-1:0]  pl_data [NCH];
  logic [BW-1:0]  pl_mask [NCH];
  int             ann_idx = 0;
  bit             ann_j1 = 0;
  int             fired_idx = 0;
  bit             fired_j1 = 0;
  int             streak = 0;
  int             tight_cd = 0;
  bit             tight_armed = 0;
  int             tight_hits = 0;
  int             timer_cd = 0;
  int             busy_cd = 0;
  int             frame_cnt = 0;
  bit             synced_tb = 0;
  int             accepted = 0;
  int             results = 0;
  int             bit7_cyc = 0;
  int             rdy_seen = 0;
  bit             valid_d = 0;
  bit             after_tight = 0;

  task automatic fire_accepted(input int c);
    bit s;
    s = !synced_tb || (frame_cnt >= NBYTES && ($urandom % 4) != 0) || (($urandom % 25) == 0);
    byte_tick = 1'b1;
    sof = s;
    synced_tb = 1;
    fired_j1 = s;
    if (s) begin
      fired_idx = 0;
      frame_cnt = 1;
    end else begin
      fired_idx = (fired_idx + 1) % NBYTES;   // R9 wrap 8 -> 0
      frame_cnt++;
    end
    accepted++;
    if (($urandom % 5) == 0 && c < RUN_END) begin
      tight_armed = 1;
      timer_cd = 0;
    end else begin
      timer_cd = 95 + int'($urandom % 40);
    end
    if (($urandom % 6) == 0) busy_cd = 30;
  endtask

  task automatic make_plan();
    for (int ch = 0; ch < NCH; ch++) begin
      int r;
      r = int'($urandom % 4);
      pl_data[ch] = BW'($urandom);
      if (r < 2)       pl_mask[ch] = '1;
      else if (r == 2) pl_mask[ch] = '0;
      else begin
        pl_mask[ch] = BW'($urandom);
        if (pl_mask[ch] == '1 || pl_mask[ch] == '0) pl_mask[ch][0] = ~pl_mask[ch][0];
      end
    end
  endtask

  initial begin
    void'($urandom(32'd7355));
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R2", "pclk in reset", int'(pclk), 0);
    check("R2", "rdy in reset", int'(rdy), 0);
    check("R2", "frame in reset", int'(frame), 0);
    check("R2", "valid in reset", int'(valid), 0);
    check("R2", "flags in reset", int'(ovr | err), 0);
    rst = 1'b0;

    for (int c = 0; c < LOOP_END; c++) begin
      bit rise;
      @(negedge clk);
      byte_tick = 1'b0;
      sof = 1'b0;

      // R1 port clock shape
      if (pclk !== pclk_d) begin
        if (pclk_changes > 0) check("R1", "pclk half period", run_len, HALF);
        pclk_changes++;
        run_len = 1;
      end else begin
        run_len++;
      end
      rise = pclk && !pclk_d;
      pclk_d = pclk;

      if (rdy) rdy_seen++;

      // results
      if (valid) begin
        check("R10", "strobe width", int'(valid_d), 0);
        check("R10", "strobe after eighth sample", c - bit7_cyc, HALF);
        check(after_tight ? "R12" : "R9", "result index", int'(idx), ann_idx);
        for (int ch = 0; ch < NCH; ch++) begin
          string rq;
          rq = (pl_mask[ch] == '1) ? "R6" : (pl_mask[ch] == '0) ? "R7" : "R8";
          check(rq, "override flag (R13 lane)", int'(ovr[ch]), exp_ovr(pl_mask[ch]));
          check(rq, "error flag (R13 lane)", int'(err[ch]), exp_err(pl_mask[ch]));
          check(rq, "byte, R5 msb first", int'(bytes[ch*BW +: BW]),
                exp_byte(pl_mask[ch], pl_data[ch]));
        end
        results++;
      end
      valid_d = valid;

      // tight trigger on the final sample edge (R12)
      if (tight_cd > 0) begin
        tight_cd--;
        if (tight_cd == 0) begin
          fire_accepted(c);
          tight_hits++;
          after_tight = 1;
        end
      end

      // external serial device
      if (rise) begin
        if (frame) streak++;
        else if (streak > 0) begin
          check("R4", "frame width in periods", streak, 8);
          streak = 0;
        end
        if (drv_cnt > 0) begin
          int bp;
          bp = BW - drv_cnt;
          if (bp == 0) check("R3", "ready lasts one period", int'(rdy), 0);
          for (int ch = 0; ch < NCH; ch++) begin
            ser[ch] = pl_data[ch][BW-1-bp];
            ins[ch] = pl_mask[ch][BW-1-bp];
          end
          drv_cnt--;
          if (drv_cnt == 0) begin
            bit7_cyc = c;
            if (tight_armed) begin
              tight_armed = 0;
              tight_cd = HALF - 1;
            end
          end
        end else begin
          ins = '0;
          ser = NCH'($urandom);
        end
        if (rdy) begin
          if (ann_idx == fired_idx && ann_j1 == fired_j1 && results == 0 && accepted == 0)
            check("R11", "ready without accepted trigger", 1, 0);
          check("R4", "frame with ready", int'(frame), int'(fired_j1));
          if (after_tight) check("R12", "next byte index", fired_idx, (ann_idx + 1) % NBYTES + (fired_j1 ? 0 : 0) - (fired_j1 ? (ann_idx + 1) % NBYTES : 0));
          ann_idx = fired_idx;
          ann_j1 = fired_j1;
          after_tight = 0;
          make_plan();
          drv_cnt = BW;
        end
      end

      // phase 0: triggers before any start-of-frame
      if (c < 800) begin
        if ((c % 150) == 149) byte_tick = 1'b1;
      end else if (c == 800) begin
        check("R2", "ready pulses before sync", rdy_seen, 0);
        timer_cd = 1;
      end

      if (c > 800 && c < RUN_END) begin
        if (timer_cd > 0) begin
          timer_cd--;
          if (timer_cd == 0) fire_accepted(c);
        end
        if (busy_cd > 0) begin
          busy_cd--;
          if (busy_cd == 0) begin
            byte_tick = 1'b1;          // R11 ignored mid-transfer
            sof = ($urandom % 2) != 0;
          end
        end
      end
    end

    check("R11", "results equal accepted triggers", results, accepted);
    check("R12", "tight triggers exercised", int'(tight_hits > 5), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", results, accepted);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule